// File: doc/BRIEF.md
# Cycle-Counting Interrupt Timer

This block raises an interrupt after a fixed number of bus clock periods. A 12-bit counter advances once for every CPU M2 cycle, which reaches the block as a single-cycle clock enable. When the counter rolls over from all ones back to zero, an interrupt request is latched and driven low towards the CPU. The request stays low until software clears it.

Software controls the timer through one write-only register with a single meaningful bit. Writing a value with bit 0 set starts the count. Writing a value with bit 0 clear clears the request, stops the count and zeroes the counter, all in one step. The register answers at two address aliases. The decode ignores address bits 9 to 11 and compares every other bit, A15 included. The counter value cannot be read back.

Top module: `cyc_irq_timer`

## Requirements
- R1: After synchronous reset the timer is stopped, the count is zero and `irq_n` is high. Ticks given before any start write never pull `irq_n` low.
- R2: A write reaches the control register only when `(wr_addr & 16'hF1FF)` equals `16'h4122` or `16'h8122`. Writes to any other address, such as `16'h4022`, `16'hC122`, `16'h4123` or `16'h5122`, change nothing. Addresses that differ only in bits 9 to 11, such as `16'h4F22`, do reach the register.
- R3: A control write with `wr_data[0]` = 0 drives `irq_n` high on the next edge, stops the count and zeroes the counter. The other data bits have no effect.
- R4: A control write with `wr_data[0]` = 1 starts the timer. From then on the count advances by one on each cycle that has `m2_tick` high, and cycles with `m2_tick` low leave it unchanged.
- R5: Starting from a zero count, `irq_n` goes low at the clock edge that samples the 4096th counted tick, and not before.
- R6: Once low, `irq_n` stays low through further ticks until a write with bit 0 = 0 arrives. The counter wraps to zero and keeps counting.
- R7: A write with bit 0 = 1 while the timer is already running keeps both the count and any pending request.
- R8: In a cycle that holds a control write, a tick on `m2_tick` is not counted. The write alone decides the next state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data; only bit 0 is used |
| wr_en | input | 1 | CPU write strobe, one cycle for each write |
| m2_tick | input | 1 | Clock enable, high for one cycle per M2 cycle |
| irq_n | output | 1 | Interrupt request to the CPU, active low |

## Verification
The assertions assume that each CPU write is presented as one `wr_en` cycle. They also assume that `m2_tick` is a plain per-cycle enable that may coincide with a write. They place no limit on how ticks and writes are spaced. The bench drives every write and every tick on the falling clock edge for exactly one cycle. It deliberately sets a tick in the same cycle as a write to reach the precedence case, and it inserts idle cycles between ticks to show that only tick cycles count. Because the count cannot be read back, the bench measures it as the number of ticks until `irq_n` falls.

// File: rtl/irqt_pkg.sv
package irqt_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int CNT_W     = 12;
    localparam int NUM_ALIAS = 2;

    localparam logic [ADDR_W-1:0] DEC_MASK = 16'hF1FF;

    localparam logic [NUM_ALIAS-1:0][ADDR_W-1:0] ALIAS_LIST = {16'h8122, 16'h4122};

    typedef enum logic {
        CMD_ACK = 1'b0,
        CMD_ARM = 1'b1
    } ctl_cmd_e;

    typedef struct packed {
        logic     valid;
        ctl_cmd_e cmd;
    } ctl_req_t;

    function automatic logic addr_match(input logic [ADDR_W-1:0] a,
                                        input logic [ADDR_W-1:0] base);
        return (a & DEC_MASK) == base;
    endfunction

endpackage

// File: rtl/irqt_decode.sv
module irqt_decode
    import irqt_pkg::*;
(
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    output ctl_req_t          req
);

    logic [NUM_ALIAS-1:0] hit_vec;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_ALIAS; gi++) begin : g_alias
            assign hit_vec[gi] = addr_match(wr_addr, ALIAS_LIST[gi]);
        end
    endgenerate

    always_comb begin
        req.valid = wr_en && (|hit_vec);
        req.cmd   = wr_data[0] ? CMD_ARM : CMD_ACK;
    end

endmodule

// File: rtl/irqt_counter.sv
module irqt_counter
    import irqt_pkg::*;
#(
    parameter int WIDTH = CNT_W
) (
    input  logic     clk,
    input  logic     rst,
    input  ctl_req_t req,
    input  logic     tick,
    output logic     pend
);

    localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] CNT_ONE = WIDTH'(1);

    typedef struct packed {
        logic             en;
        logic             pend;
        logic [WIDTH-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (req.valid) begin
            if (req.cmd == CMD_ACK) begin
                st_d.en   = 1'b0;
                st_d.pend = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.en = 1'b1;
            end
        end else if (st_q.en && tick) begin
            st_d.cnt = st_q.cnt + CNT_ONE;
            if (st_q.cnt == CNT_MAX) begin
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

    // R3
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.cmd == CMD_ACK) |=> (!pend && !st_q.en && st_q.cnt == '0));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.en && tick && !req.valid) |=> (st_q.cnt == $past(st_q.cnt) + CNT_ONE));

    // R5
    overflow_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.en && tick && !req.valid && st_q.cnt == CNT_MAX) |=> (pend && st_q.cnt == '0));

    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !(req.valid && req.cmd == CMD_ACK)) |=> pend);

    // R7
    arm_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.cmd == CMD_ARM) |=> (st_q.en && $stable(st_q.cnt) && $stable(pend)));

    // R8
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.cmd == CMD_ARM && tick) |=> $stable(st_q.cnt));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!st_q.en && !req.valid) |=> ($stable(st_q.cnt) && !st_q.en));

endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
    import irqt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    input  logic              m2_tick,
    output logic              irq_n
);

    ctl_req_t ctl_req;
    logic     irq_pend;

    irqt_decode u_decode (
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_en   (wr_en),
        .req     (ctl_req)
    );

    irqt_counter #(.WIDTH(CNT_W)) u_counter (
        .clk  (clk),
        .rst  (rst),
        .req  (ctl_req),
        .tick (m2_tick),
        .pend (irq_pend)
    );

    assign irq_n = ~irq_pend;

    // R2
    stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_req.valid && !irq_n) |=> !irq_n);

    // R3
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_req.valid && !wr_data[0]) |=> irq_n);

endmodule

// File: tb/test_cyc_irq_timer.sv
module test_cyc_irq_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_en = 1'b0;
    logic        m2_tick = 1'b0;
    logic        irq_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    cyc_irq_timer i_cyc_irq_timer (
        .clk     (clk),
        .rst     (rst),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_en   (wr_en),
        .m2_tick (m2_tick),
        .irq_n   (irq_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [15:0] a, input logic [7:0] d, input bit tk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        m2_tick = tk;
        @(negedge clk);
        wr_en   = 1'b0;
        m2_tick = 1'b0;
    endtask

    task automatic run_ticks(input int n, input bit gap);
        for (int i = 0; i < n; i++) begin
            m2_tick = 1'b1;
            @(negedge clk);
            m2_tick = 1'b0;
            if (gap) @(negedge clk);
        end
    endtask

    task automatic ticks_to_irq(input int limit, output int n);
        n = 0;
        m2_tick = 1'b1;
        while (n < limit) begin
            @(negedge clk);
            n++;
            if (!irq_n) break;
        end
        m2_tick = 1'b0;
    endtask

    task automatic t_reset;
        int n;
        check(irq_n == 1'b1, "R1 reset irq_n", irq_n, 1);
        ticks_to_irq(5000, n);
        check(irq_n == 1'b1, "R1 ticks before start", irq_n, 1);
    endtask

    task automatic t_basic;
        int n;
        ctl_write(16'h4122, 8'h01, 1'b0);
        ticks_to_irq(5000, n);
        check(n == 4096, "R5 ticks to overflow", n, 4096);
        check(irq_n == 1'b0, "R4 timer counted", irq_n, 0);
    endtask

    task automatic t_hold_ack;
        int n;
        run_ticks(100, 1'b0);
        check(irq_n == 1'b0, "R6 held through ticks", irq_n, 0);
        ctl_write(16'h8122, 8'h01, 1'b0);
        check(irq_n == 1'b0, "R7 arm keeps pending", irq_n, 0);
        ctl_write(16'h8122, 8'hFE, 1'b0);
        check(irq_n == 1'b1, "R3 ack releases", irq_n, 1);
        ticks_to_irq(5000, n);
        check(irq_n == 1'b1, "R3 ack stops count", irq_n, 1);
    endtask

    task automatic t_decode;
        int n;
        ctl_write(16'h8122, 8'h01, 1'b0);
        ticks_to_irq(5000, n);
        check(n == 4096, "R2 alias 8122 start", n, 4096);
        ctl_write(16'h4022, 8'h00, 1'b0);
        check(irq_n == 1'b0, "R2 4022 ignored", irq_n, 0);
        ctl_write(16'hC122, 8'h00, 1'b0);
        check(irq_n == 1'b0, "R2 C122 ignored", irq_n, 0);
        ctl_write(16'h4123, 8'h00, 1'b0);
        check(irq_n == 1'b0, "R2 4123 ignored", irq_n, 0);
        ctl_write(16'h4F22, 8'h00, 1'b0);
        check(irq_n == 1'b1, "R2 4F22 mirror acks", irq_n, 1);
        ctl_write(16'h5122, 8'h01, 1'b0);
        ticks_to_irq(5000, n);
        check(irq_n == 1'b1, "R2 5122 start ignored", irq_n, 1);
    endtask

    task automatic t_rearm;
        int n;
        ctl_write(16'h4122, 8'hF1, 1'b0);
        run_ticks(1000, 1'b0);
        ctl_write(16'h4122, 8'h01, 1'b0);
        ticks_to_irq(5000, n);
        check(n == 3096, "R7 arm keeps count", n, 3096);
        ctl_write(16'h4122, 8'h00, 1'b0);
    endtask

    task automatic t_ack_mid;
        int n;
        ctl_write(16'h4122, 8'h01, 1'b0);
        run_ticks(1500, 1'b0);
        ctl_write(16'h4122, 8'h00, 1'b0);
        ctl_write(16'h4122, 8'h01, 1'b0);
        run_ticks(4095, 1'b1);
        check(irq_n == 1'b1, "R4 gaps not counted", irq_n, 1);
        ticks_to_irq(10, n);
        check(n == 1, "R3 ack zeroed count", n, 1);
        ctl_write(16'h4122, 8'h00, 1'b0);
    endtask

    task automatic t_same_cycle;
        int n;
        ctl_write(16'h4122, 8'h01, 1'b0);
        run_ticks(4095, 1'b0);
        ctl_write(16'h4122, 8'h01, 1'b1);
        check(irq_n == 1'b1, "R8 tick lost to write", irq_n, 1);
        ticks_to_irq(10, n);
        check(n == 1, "R8 one tick left", n, 1);
        ctl_write(16'h4122, 8'h00, 1'b1);
        ctl_write(16'h4122, 8'h01, 1'b1);
        ticks_to_irq(5000, n);
        check(n == 4096, "R8 ack with tick", n, 4096);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_hold_ack();
        t_decode();
        t_rearm();
        t_ack_mid();
        t_same_cycle();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule